// File: doc/BRIEF.md
# I2C Stop Sequencer with Collision Detection

This block is the master-side piece that closes an I2C transfer. When it sees a one-cycle request in idle, it takes SDA low and holds SCL low. It then lets SCL float and waits for the line to read high, so a slave or another master that stretches the clock delays the sequence. From that point it times a hold period with a reloadable down-counter. After the hold period it lets SDA rise, times a second period, and then samples SDA. A high reading ends the sequence with a one-cycle done pulse. A low reading means another master is driving a zero.

The block also detects a collision if SCL reads low after it has been seen high and before the sequence ends. On either collision the block releases both lines in the same cycle, returns to idle, and sets a sticky collision flag. That flag stays set until a clear input is pulsed.

Both line inputs pass through a two-flop synchroniser before any decision uses them. There is no data stream here, so every pin is a plain control or status signal with no valid/ready handshake. The drive outputs are drive-low enables for open-drain pads. A 1 pulls the line low and a 0 lets it float.

Top module: `i2c_stop_seq`

## Requirements
- R1: After reset both drive-low enables are 0, the collision flag is 0 and the done pulse is 0.
- R2: A stop request accepted in idle sets both drive-low enables to 1 in the next cycle. SCL stays driven low until the synchronised SDA reads low. The SCL enable drops exactly 3 clocks after SDA first reads low at the pin.
- R3: While SCL is released but still reads low (stretching), the block waits with no time limit and keeps SDA driven low. During this wait it does not report a collision.
- R4: Let N be the reload value, or 1 when the reload value is 0. The SDA enable drops exactly N+3 clocks after SCL rises at the pin.
- R5: Suppose SDA reads high at the end of the second period, which lasts N+2 clocks to cover the synchroniser delay. The done output is then 1 for exactly one cycle, 2N+5 clocks after SCL rose at the pin. The block then returns to idle with both lines released.
- R6: If SDA reads low at the end of the second period, the collision flag is set 2N+5 clocks after SCL rose. Both enables are 0 at that point and no done pulse follows.
- R7: Suppose SCL reads low at the pin d clocks after it rose, with 1 ≤ d ≤ 2N+2. The collision flag is then set d+3 clocks after the rise, with both lines released and no done pulse.
- R8: The collision flag holds its value until the clear input is pulsed, and reads 0 in the cycle after that pulse.
- R9: A stop request that arrives while a sequence is in progress changes neither the outcome nor the timing. It also does not start a new sequence afterwards.
- R10: A reload value of 0 gives one-clock timing periods (N = 1), never a zero-length or wrapped count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | One-cycle request to run a Stop sequence |
| reload | input | 7 | Period length in clocks (0 is treated as 1) |
| coll_clr | input | 1 | Clears the sticky collision flag |
| sda_in | input | 1 | Raw SDA pin level |
| scl_in | input | 1 | Raw SCL pin level |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| coll_flag | output | 1 | Sticky bus-collision flag |
| stop_done | output | 1 | One-cycle pulse on a clean Stop |

## Verification
Clean Stops run across random reload values and random clock-stretch lengths, and each run is checked for the exact SDA release and done cycles. These runs separate correct period arithmetic from off-by-one and synchroniser-latency errors. Runs where a foreign master holds SDA low test detection at the sample point. Runs with SCL pulled low at a random offset test detection at each distance from the rise. Directed cases cover:
- a stuck-high SDA that must hold SCL,
- a zero reload value,
- a request during a busy sequence,
- the sticky flag and its clear.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SDA_LOW,
    ST_SCL_REL,
    ST_HOLD,
    ST_VERIFY
  } stop_state_e;
endpackage

// File: rtl/i2c_stop_sync.sv
module i2c_stop_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] synced
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_stop_brg.sv
module i2c_stop_brg #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == CW'(1));

  AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt != '0); // R10
endmodule

// File: rtl/i2c_stop_fsm.sv
module i2c_stop_fsm
  import i2c_stop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic coll_clr,
  input  logic sda_s,
  input  logic scl_s,
  input  logic tick,
  output logic load,
  output logic load_long,
  output logic sda_dl,
  output logic scl_dl,
  output logic coll_flag,
  output logic done
);
  stop_state_e state_q, state_d;
  logic sda_d, scl_d, coll_set, fin;

  always_comb begin
    state_d   = state_q;
    sda_d     = sda_dl;
    scl_d     = scl_dl;
    load      = 1'b0;
    load_long = 1'b0;
    coll_set  = 1'b0;
    fin       = 1'b0;
    unique case (state_q)
      ST_IDLE: if (stop_req) begin
        state_d = ST_SDA_LOW;
        sda_d   = 1'b1;
        scl_d   = 1'b1;
      end
      ST_SDA_LOW: if (!sda_s) begin
        state_d = ST_SCL_REL;
        scl_d   = 1'b0;
      end
      ST_SCL_REL: if (scl_s) begin
        state_d = ST_HOLD;
        load    = 1'b1;
      end
      ST_HOLD: begin
        if (!scl_s) coll_set = 1'b1;
        else if (tick) begin
          state_d   = ST_VERIFY;
          sda_d     = 1'b0;
          load      = 1'b1;
          load_long = 1'b1;
        end
      end
      ST_VERIFY: begin
        if (!scl_s) coll_set = 1'b1;
        else if (tick) begin
          if (sda_s) fin = 1'b1;
          else       coll_set = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (coll_set || fin) begin
      state_d = ST_IDLE;
      sda_d   = 1'b0;
      scl_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sda_dl    <= 1'b0;
      scl_dl    <= 1'b0;
      coll_flag <= 1'b0;
      done      <= 1'b0;
    end else begin
      state_q <= state_d;
      sda_dl  <= sda_d;
      scl_dl  <= scl_d;
      done    <= fin;
      if (coll_set)      coll_flag <= 1'b1;
      else if (coll_clr) coll_flag <= 1'b0;
    end
  end

  AST_SCL_AFTER_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_dl) && !$rose(coll_flag)) |-> !$past(sda_s)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_COLL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_flag) |-> (!sda_dl && !scl_dl && !done)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_flag && !coll_clr) |=> coll_flag); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && stop_req && scl_s && !tick) |=> state_q == ST_HOLD); // R9
endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq #(
  parameter int RELOAD_W    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_req,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                coll_clr,
  input  logic                sda_in,
  input  logic                scl_in,
  output logic                sda_drive_low,
  output logic                scl_drive_low,
  output logic                coll_flag,
  output logic                stop_done
);
  localparam int CW = RELOAD_W + 2;

  logic [1:0]    synced;
  logic          load, load_long, tick;
  logic [CW-1:0] period, load_val;

  i2c_stop_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}), .synced(synced)
  );

  assign period   = (reload == '0) ? CW'(1) : CW'(reload);
  assign load_val = load_long ? period + CW'(SYNC_STAGES) : period;

  i2c_stop_brg #(.CW(CW)) u_brg (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .tick(tick)
  );

  i2c_stop_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .coll_clr(coll_clr),
    .sda_s(synced[0]), .scl_s(synced[1]), .tick(tick),
    .load(load), .load_long(load_long),
    .sda_dl(sda_drive_low), .scl_dl(scl_drive_low),
    .coll_flag(coll_flag), .done(stop_done)
  );
endmodule

// File: tb/i2c_stop_seq_bench.sv
module i2c_stop_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0;
  logic [6:0] reload = '0;
  logic coll_clr = 1'b0;
  logic ext_sda_low = 1'b0, ext_scl_low = 1'b0, sda_force_high = 1'b0;
  logic sda_drive_low, scl_drive_low, coll_flag, stop_done;
  logic sda_in, scl_in;
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;

  assign sda_in = !(sda_drive_low | ext_sda_low) | sda_force_high;
  assign scl_in = !(scl_drive_low | ext_scl_low);

  always #4 clk = ~clk;

  i2c_stop_seq u_i2c_stop_seq (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .reload(reload),
    .coll_clr(coll_clr), .sda_in(sda_in), .scl_in(scl_in),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
    .coll_flag(coll_flag), .stop_done(stop_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_n(input int r);
    return (r == 0) ? 1 : r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // mode 0: clean, 1: foreign SDA low, 2: foreign SCL low at offset d
  task automatic run_stop(input int r, input int stretch, input int mode,
                          input int d, input bit poke);
    int n, k, rel_k, done_k, coll_k, nn;
    nn = eff_n(r);
    rel_k = -1; done_k = -1; coll_k = -1;
    @(negedge clk);
    reload = 7'(r);
    ext_scl_low = 1'b1;
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk(sda_drive_low && scl_drive_low, "R2 drives on request", {sda_drive_low, scl_drive_low}, 3);
    n = 0;
    while (scl_drive_low && n < 100) begin @(negedge clk); n++; end
    chk(n == 3, "R2 SCL release delay", n, 3);
    for (int i = 0; i < stretch; i++) begin
      @(negedge clk);
      chk(!coll_flag && sda_drive_low, "R3 stretch wait", {coll_flag, sda_drive_low}, 1);
    end
    if (mode == 1) ext_sda_low = 1'b1;
    ext_scl_low = 1'b0;
    k = 0;
    while (k < 1000 && done_k < 0 && coll_k < 0) begin
      @(negedge clk);
      k++;
      if (poke && k == 1) stop_req = 1'b1;
      if (poke && k == 2) stop_req = 1'b0;
      if (mode == 2 && k == d) ext_scl_low = 1'b1;
      if (!sda_drive_low && rel_k < 0) rel_k = k;
      if (stop_done) done_k = k;
      if (coll_flag) coll_k = k;
    end
    if (mode == 0) begin
      chk(rel_k == nn + 3, "R4 SDA release time", rel_k, nn + 3);
      chk(done_k == 2 * nn + 5, "R5 done time", done_k, 2 * nn + 5);
      chk(coll_k < 0, "R3 no collision on clean stop", coll_k, -1);
      chk(!sda_drive_low && !scl_drive_low, "R5 lines released", {sda_drive_low, scl_drive_low}, 0);
      @(negedge clk);
      chk(!stop_done, "R5 done one cycle", stop_done, 0);
    end else if (mode == 1) begin
      chk(rel_k == nn + 3, "R4 SDA release time", rel_k, nn + 3);
      chk(coll_k == 2 * nn + 5, "R6 SDA collision time", coll_k, 2 * nn + 5);
      chk(done_k < 0, "R6 no done", done_k, -1);
      chk(!sda_drive_low && !scl_drive_low, "R6 lines released", {sda_drive_low, scl_drive_low}, 0);
    end else begin
      chk(coll_k == d + 3, "R7 SCL collision time", coll_k, d + 3);
      chk(done_k < 0, "R7 no done", done_k, -1);
      chk(!sda_drive_low && !scl_drive_low, "R7 lines released", {sda_drive_low, scl_drive_low}, 0);
    end
    ext_sda_low = 1'b0;
    ext_scl_low = 1'b0;
    if (mode != 0) begin
      repeat (3) @(negedge clk);
      chk(coll_flag, "R8 flag sticky", coll_flag, 1);
      coll_clr = 1'b1;
      @(negedge clk);
      coll_clr = 1'b0;
      chk(!coll_flag, "R8 flag cleared", coll_flag, 0);
    end
    if (poke) begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(!sda_drive_low && !scl_drive_low && !stop_done, "R9 no restart",
            {sda_drive_low, scl_drive_low, stop_done}, 0);
      end
    end
  endtask

  initial begin
    int r, s, m, d, junk;
    junk = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    chk(!sda_drive_low && !scl_drive_low && !coll_flag && !stop_done, "R1 reset state",
        {sda_drive_low, scl_drive_low, coll_flag, stop_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sda_drive_low && !scl_drive_low && !coll_flag && !stop_done, "R1 after reset",
        {sda_drive_low, scl_drive_low, coll_flag, stop_done}, 0);

    // directed corners
    run_stop(0, 0, 0, 0, 1'b0);            // R10 zero reload
    run_stop(0, 2, 1, 0, 1'b0);            // R10 with SDA collision
    run_stop(1, 0, 2, 1, 1'b0);            // R7 earliest offset
    run_stop(3, 0, 2, 8, 1'b0);            // R7 latest offset 2N+2
    run_stop(127, 40, 0, 0, 1'b0);         // R4 largest reload, long stretch
    run_stop(5, 3, 0, 0, 1'b1);            // R9 request while busy

    // R2 stuck-high SDA holds SCL
    @(negedge clk);
    sda_force_high = 1'b1;
    reload = 7'd2;
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    repeat (20) @(negedge clk);
    chk(scl_drive_low, "R2 SCL held while SDA reads high", scl_drive_low, 1);
    sda_force_high = 1'b0;
    begin
      int n;
      n = 0;
      while (scl_drive_low && n < 100) begin @(negedge clk); n++; end
      chk(n == 3, "R2 release after SDA low", n, 3);
    end
    begin
      int k;
      k = 0;
      while (!stop_done && k < 100) begin @(negedge clk); k++; end
      chk(stop_done, "R5 stuck case completes", stop_done, 1);
    end

    // constrained random
    for (int it = 0; it < 45; it++) begin
      r = $urandom_range(0, 127);
      s = $urandom_range(0, 25);
      m = $urandom_range(0, 2);
      d = $urandom_range(1, 2 * eff_n(r) + 2);
      run_stop(r, s, m, d, ($urandom_range(0, 3) == 0) && (m == 0));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule